// File: doc/BRIEF.md
# Test Program Instruction Sequencer

This block is a small programmable controller that steps through a test program held in a synchronous program memory and uses it to exercise one selected processing core. Each instruction is 24 bits wide and moves through three phases: the program memory is read at the program counter, the word is captured into the instruction register, and the instruction is executed. Execution begins when the host sets the run bit. It ends when a stop instruction executes or when the return-address stack is misused.

Program control is handled in the block itself: jumps, subroutine calls and returns through a small return-address stack, and timed waits. Module select and motion vector writes are also handled here and take a single execute cycle. Memory-access and address-setting instructions are handed to an external address-sequence generator. The block raises a one-cycle start pulse together with the opcode and the operand field, then stalls until the generator reports done. When a program ends, a sticky interrupt bit is raised. The host polls this bit and clears it by writing one.

Top module: `test_seq`

## Requirements
- R1: Reset state: run, interrupt and error outputs are 0, no program memory read and no generator start are issued, and the module select and motion vector outputs are 0.
- R2: When `run_set_i` is sampled high while the sequencer is idle, `run_o` rises on that edge and the next cycle reads program memory address 0. A `run_set_i` pulse while running is ignored.
- R3: An instruction word is {opcode[23:20], nibble[19:16], high byte[15:8], low byte[7:0]}. Each instruction takes a read cycle, a capture cycle and at least one execute cycle, so instructions that finish in one execute cycle are read every 3 cycles.
- R4: Opcode 6 (jump) loads the program counter with bits [PC_W-1:0] of the instruction, and the next read is at that address.
- R5: Opcode 7 (call) jumps like opcode 6 and saves the address after the call. Opcode 8 (return) resumes at the most recently saved address. Nested calls return in LIFO order.
- R6: Opcode 9 (wait) takes its count n from bits [15:0] and ignores bits [19:16]. It adds n cycles before the next read, so that read comes 3+n cycles after the wait was read.
- R7: Opcode 11 (set module) loads `mod_sel_o` from bits [7:0]. Opcode 12 (set motion vector) loads `mv_x_o` from bits [15:8] and `mv_y_o` from bits [7:0]. Both finish in one execute cycle.
- R8: Opcodes 0 to 5 raise `mem_start_o` for exactly one cycle, in the first execute cycle. During that pulse `mem_op_o` holds opcode[2:0] and `mem_arg_o` holds bits [19:0]. The sequencer then stalls until `mem_done_i` is high, and `mem_done_i` in the start cycle is not counted. If done arrives L cycles after the start, the next read follows the memory instruction's read by 3+L cycles.
- R9: Opcode 10 (stop) clears `run_o` in hardware and sets `irq_o`. `irq_o` stays set until `irq_clr_i` is pulsed, and no further reads are made.
- R10: The stack holds STACK_DEPTH (default 4) return addresses. A call on a full stack, or a return on an empty stack, sets `err_o`, clears `run_o` and sets `irq_o`. `err_o` clears when the next run starts.
- R11: Opcodes 13 to 15 change no output and advance to the next address in one execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_set_i | input | 1 | Host pulse that sets the run bit and starts the program at address 0 |
| irq_clr_i | input | 1 | Host pulse that clears the completion interrupt |
| run_o | output | 1 | Run bit |
| irq_o | output | 1 | Sticky completion interrupt |
| err_o | output | 1 | Stack misuse flag |
| pm_en_o | output | 1 | Program memory read enable |
| pm_addr_o | output | PC_W | Program memory read address |
| pm_data_i | input | 24 | Program memory read data, valid one cycle after the enable |
| mem_start_o | output | 1 | Start pulse to the address-sequence generator |
| mem_op_o | output | 3 | Memory instruction kind (opcode bits 2:0) |
| mem_arg_o | output | 20 | Memory instruction operand field |
| mem_done_i | input | 1 | Generator completion |
| mod_sel_o | output | 8 | Selected module number |
| mv_x_o | output | 8 | Motion vector, horizontal |
| mv_y_o | output | 8 | Motion vector, vertical |

## Verification
A wrong program counter or a corrupted stack entry shows up at `pm_addr_o` on the very next read, at most a few cycles after the faulty instruction executes. A wrong wait count or a broken generator handshake changes the gap between reads by a whole number of cycles. The bench therefore scores every read as an (address, cycle gap) pair and every generator start as an (op, operand) pair. State that is only visible at the end of a program, such as the module and vector registers, the interrupt and the error flag, is compared once the run bit drops.

// File: rtl/test_seq_pkg.sv
`timescale 1ns/1ps
package test_seq_pkg;

  localparam int INSTR_W = 24;
  localparam int ARG_W   = 20;

  localparam logic [3:0] OP_JUMP    = 4'h6;
  localparam logic [3:0] OP_CALL    = 4'h7;
  localparam logic [3:0] OP_RET     = 4'h8;
  localparam logic [3:0] OP_WAIT    = 4'h9;
  localparam logic [3:0] OP_STOP    = 4'hA;
  localparam logic [3:0] OP_SET_MOD = 4'hB;
  localparam logic [3:0] OP_SET_MV  = 4'hC;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] nib;
    logic [7:0] hi;
    logic [7:0] lo;
  } instr_t;

  typedef struct packed {
    logic is_mem;
    logic is_jump;
    logic is_call;
    logic is_ret;
    logic is_wait;
    logic is_stop;
    logic is_mod;
    logic is_mv;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC
  } state_e;

endpackage

// File: rtl/instr_decode.sv
`timescale 1ns/1ps
module instr_decode
  import test_seq_pkg::*;
(
  input  instr_t ir_i,
  output dec_t   dec_o
);

  always_comb begin
    dec_o         = '0;
    dec_o.is_mem  = (ir_i.op < 4'h6);
    dec_o.is_jump = (ir_i.op == OP_JUMP);
    dec_o.is_call = (ir_i.op == OP_CALL);
    dec_o.is_ret  = (ir_i.op == OP_RET);
    dec_o.is_wait = (ir_i.op == OP_WAIT);
    dec_o.is_stop = (ir_i.op == OP_STOP);
    dec_o.is_mod  = (ir_i.op == OP_SET_MOD);
    dec_o.is_mv   = (ir_i.op == OP_SET_MV);
  end

endmodule

// File: rtl/ret_stack.sv
`timescale 1ns/1ps
module ret_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0]           sp_q;
  logic [DEPTH-1:0][AW-1:0]  ent;
  logic [IDX_W-1:0]          top_idx;

  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign top_idx = IDX_W'(sp_q - 1'b1);
  assign top_o   = ent[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sp_q <= '0;
    else if (clear_i)         sp_q <= '0;
    else if (push_i && !full_o) sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o) sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= '0;
      else if (push_i && sp_q == SP_W'(g))       q <= push_data_i;
    end
    assign ent[g] = q;
  end

  p_sp_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_W'(DEPTH));
  p_no_push_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_pop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/wait_timer.sv
`timescale 1ns/1ps
module wait_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= count_i;
    else if (dec_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  // R6: once drained, the count stays at zero until reloaded
  p_zero_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/test_seq.sv
`timescale 1ns/1ps
module test_seq
  import test_seq_pkg::*;
#(
  parameter int PC_W        = 8,
  parameter int STACK_DEPTH = 4,
  parameter int WAIT_W      = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_set_i,
  input  logic                irq_clr_i,
  output logic                run_o,
  output logic                irq_o,
  output logic                err_o,
  output logic                pm_en_o,
  output logic [PC_W-1:0]     pm_addr_o,
  input  logic [INSTR_W-1:0]  pm_data_i,
  output logic                mem_start_o,
  output logic [2:0]          mem_op_o,
  output logic [ARG_W-1:0]    mem_arg_o,
  input  logic                mem_done_i,
  output logic [7:0]          mod_sel_o,
  output logic [7:0]          mv_x_o,
  output logic [7:0]          mv_y_o
);

  state_e          state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, dest;
  instr_t          ir_q;
  dec_t            dec;
  logic            run_q, irq_q, err_q, issued_q;
  logic [7:0]      mod_q, mvx_q, mvy_q;

  logic            in_exec, start, err_stop, finish, adv;
  logic            push, pop, stk_full, stk_empty;
  logic [PC_W-1:0] stk_top;
  logic            wait_zero;

  instr_decode u_dec (
    .ir_i  (ir_q),
    .dec_o (dec)
  );

  ret_stack #(
    .DEPTH (STACK_DEPTH),
    .AW    (PC_W)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (pc_inc),
    .top_o       (stk_top),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  wait_timer #(
    .W (WAIT_W)
  ) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == ST_DECODE),
    .count_i (pm_data_i[WAIT_W-1:0]),
    .dec_i   (in_exec && dec.is_wait),
    .zero_o  (wait_zero)
  );

  assign in_exec  = (state_q == ST_EXEC);
  assign start    = (state_q == ST_IDLE) && run_set_i;
  assign pc_inc   = pc_q + PC_W'(1);
  assign dest     = PC_W'({ir_q.hi, ir_q.lo});
  assign push     = in_exec && dec.is_call && !stk_full;
  assign pop      = in_exec && dec.is_ret && !stk_empty;
  assign err_stop = in_exec && ((dec.is_call && stk_full) || (dec.is_ret && stk_empty));
  assign finish   = (in_exec && dec.is_stop) || err_stop;

  // execute phase complete, continue with next fetch
  always_comb begin
    adv = 1'b0;
    if (in_exec && !finish) begin
      if (dec.is_mem)       adv = issued_q && mem_done_i;
      else if (dec.is_wait) adv = wait_zero;
      else                  adv = 1'b1;
    end
  end

  always_comb begin
    pc_d = pc_q;
    if (start) begin
      pc_d = '0;
    end else if (adv) begin
      if (dec.is_jump || dec.is_call) pc_d = dest;
      else if (dec.is_ret)            pc_d = stk_top;
      else                            pc_d = pc_inc;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        if (finish)   state_d = ST_IDLE;
        else if (adv) state_d = ST_FETCH;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      ir_q     <= '0;
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      issued_q <= 1'b0;
      mod_q    <= '0;
      mvx_q    <= '0;
      mvy_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      if (state_q == ST_DECODE) ir_q <= pm_data_i;

      if (start)       run_q <= 1'b1;
      else if (finish) run_q <= 1'b0;

      if (finish)         irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;

      if (start)         err_q <= 1'b0;
      else if (err_stop) err_q <= 1'b1;

      if (mem_start_o)          issued_q <= 1'b1;
      else if (state_d != ST_EXEC) issued_q <= 1'b0;

      if (in_exec && dec.is_mod) mod_q <= ir_q.lo;
      if (in_exec && dec.is_mv) begin
        mvx_q <= ir_q.hi;
        mvy_q <= ir_q.lo;
      end
    end
  end

  assign run_o       = run_q;
  assign irq_o       = irq_q;
  assign err_o       = err_q;
  assign pm_en_o     = (state_q == ST_FETCH);
  assign pm_addr_o   = pc_q;
  assign mem_start_o = in_exec && dec.is_mem && !issued_q;
  assign mem_op_o    = ir_q.op[2:0];
  assign mem_arg_o   = {ir_q.nib, ir_q.hi, ir_q.lo};
  assign mod_sel_o   = mod_q;
  assign mv_x_o      = mvx_q;
  assign mv_y_o      = mvy_q;

  p_start_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && run_set_i) |=> (pm_en_o && pm_addr_o == '0 && run_o));
  p_fetch_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_en_o |=> (!pm_en_o && !mem_start_o));
  p_mem_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_start_o |=> !mem_start_o);
  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (!pm_en_o && !mem_start_o));
  p_err_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!run_o && irq_o));

endmodule

// File: tb/test_seq_tb.sv
`timescale 1ns/1ps
module test_seq_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_set_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic        run_o, irq_o, err_o, pm_en_o, mem_start_o;
  logic [7:0]  pm_addr_o, mod_sel_o, mv_x_o, mv_y_o;
  logic [23:0] pm_data_i = '0;
  logic [2:0]  mem_op_o;
  logic [19:0] mem_arg_o;
  logic        mem_done_i = 1'b0;

  logic [23:0] pm [256];
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  int cyc = 0;
  int last_fetch = 0;

  int    fa_q[$];
  int    fg_q[$];
  string ft_q[$];
  int    mop_q[$];
  int    marg_q[$];
  int    mlat_q[$];

  always #2.5 clk = ~clk;

  test_seq u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .run_set_i   (run_set_i),
    .irq_clr_i   (irq_clr_i),
    .run_o       (run_o),
    .irq_o       (irq_o),
    .err_o       (err_o),
    .pm_en_o     (pm_en_o),
    .pm_addr_o   (pm_addr_o),
    .pm_data_i   (pm_data_i),
    .mem_start_o (mem_start_o),
    .mem_op_o    (mem_op_o),
    .mem_arg_o   (mem_arg_o),
    .mem_done_i  (mem_done_i),
    .mod_sel_o   (mod_sel_o),
    .mv_x_o      (mv_x_o),
    .mv_y_o      (mv_y_o)
  );

  // synchronous program memory model
  always @(posedge clk) if (pm_en_o) pm_data_i <= pm[pm_addr_o];

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(logic [3:0] op, logic [19:0] arg);
    return {op, arg};
  endfunction

  task automatic clear_pm();
    for (int i = 0; i < 256; i++) pm[i] = mk(4'hA, 20'h0);
  endtask

  task automatic exp_fetch(int addr, int gap, string tag);
    fa_q.push_back(addr);
    fg_q.push_back(gap);
    ft_q.push_back(tag);
  endtask

  task automatic exp_mem(int op, int arg, int lat);
    mop_q.push_back(op);
    marg_q.push_back(arg);
    mlat_q.push_back(lat);
  endtask

  task automatic run_prog();
    @(negedge clk) run_set_i = 1'b1;
    @(negedge clk) run_set_i = 1'b0;
    while (run_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_irq();
    @(negedge clk) irq_clr_i = 1'b1;
    @(negedge clk) irq_clr_i = 1'b0;
  endtask

  // fetch monitor: scoreboard of (address, gap)
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && pm_en_o) begin
      if (fa_q.size() == 0) begin
        check("R9", "unexpected fetch addr", int'(pm_addr_o), -1);
      end else begin
        int a, g;
        string t;
        a = fa_q.pop_front();
        g = fg_q.pop_front();
        t = ft_q.pop_front();
        check(t, "fetch addr", int'(pm_addr_o), a);
        if (g >= 0) check(t, "fetch gap", cyc - last_fetch, g);
      end
      last_fetch = cyc;
    end
  end

  // address generator model and its monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && mem_start_o) begin
        int lat;
        if (mop_q.size() == 0) begin
          check("R8", "unexpected mem start", int'(mem_op_o), -1);
          lat = 1;
        end else begin
          check("R8", "mem op", int'(mem_op_o), mop_q.pop_front());
          check("R8", "mem arg", int'(mem_arg_o), marg_q.pop_front());
          lat = mlat_q.pop_front();
        end
        repeat (lat) @(negedge clk);
        mem_done_i = 1'b1;
        @(negedge clk);
        mem_done_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_pm();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "run", int'(run_o), 0);
    check("R1", "irq", int'(irq_o), 0);
    check("R1", "err", int'(err_o), 0);
    check("R1", "pm_en", int'(pm_en_o), 0);
    check("R1", "mod", int'(mod_sel_o), 0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // program A: register writes, no-op, wait, jump, nested calls, memory ops
    pm[0]  = mk(4'hB, 20'h0005A);
    pm[1]  = mk(4'hC, 20'h012F3);
    pm[2]  = mk(4'hD, 20'hFFFFF);
    pm[3]  = mk(4'h9, 20'hF0005);
    pm[4]  = mk(4'h6, 20'h00010);
    pm[16] = mk(4'h7, 20'h00020);
    pm[17] = mk(4'h0, 20'h70307);
    pm[18] = mk(4'h9, 20'h00000);
    pm[19] = mk(4'hF, 20'h12345);
    pm[20] = mk(4'hA, 20'h0);
    pm[32] = mk(4'h7, 20'h00030);
    pm[33] = mk(4'h8, 20'h0);
    pm[48] = mk(4'h3, 20'hABCDE);
    pm[49] = mk(4'h8, 20'h0);
    exp_fetch(0,  -1, "R2");
    exp_fetch(1,   3, "R7");
    exp_fetch(2,   3, "R7");
    exp_fetch(3,   3, "R11");
    exp_fetch(4,   8, "R6");
    exp_fetch(16,  3, "R4");
    exp_fetch(32,  3, "R5");
    exp_fetch(48,  3, "R5");
    exp_fetch(49,  5, "R8");
    exp_fetch(33,  3, "R3");
    exp_fetch(17,  3, "R5");
    exp_fetch(18,  7, "R8");
    exp_fetch(19,  3, "R6");
    exp_fetch(20,  3, "R11");
    exp_mem(3, 'hABCDE, 2);
    exp_mem(0, 'h70307, 4);
    run_prog();
    check("R7", "mod_sel", int'(mod_sel_o), 'h5A);
    check("R7", "mv_x", int'(mv_x_o), 'h12);
    check("R7", "mv_y", int'(mv_y_o), 'hF3);
    check("R9", "run after stop", int'(run_o), 0);
    check("R9", "irq after stop", int'(irq_o), 1);
    check("R10", "err clean run", int'(err_o), 0);
    check("R3", "fetch queue drained", fa_q.size(), 0);
    check("R8", "mem queue drained", mop_q.size(), 0);
    repeat (4) @(negedge clk);
    check("R9", "irq sticky", int'(irq_o), 1);
    clr_irq();
    check("R9", "irq cleared", int'(irq_o), 0);

    // program B: stack overflow on the fifth nested call
    clear_pm();
    for (int i = 0; i < 5; i++) pm[i] = mk(4'h7, 20'(i + 1));
    exp_fetch(0, -1, "R2");
    for (int i = 1; i < 5; i++) exp_fetch(i, 3, "R10");
    run_prog();
    check("R10", "err overflow", int'(err_o), 1);
    check("R10", "run overflow", int'(run_o), 0);
    check("R10", "irq overflow", int'(irq_o), 1);
    check("R10", "fetch queue overflow", fa_q.size(), 0);
    clr_irq();

    // program C: return on empty stack
    clear_pm();
    pm[0] = mk(4'h8, 20'h0);
    exp_fetch(0, -1, "R2");
    run_prog();
    check("R10", "err underflow", int'(err_o), 1);
    check("R10", "irq underflow", int'(irq_o), 1);
    clr_irq();

    // program D: start pulse during a long wait is ignored; err clears on start
    clear_pm();
    pm[0] = mk(4'h9, 20'h00014);
    pm[1] = mk(4'hA, 20'h0);
    exp_fetch(0, -1, "R2");
    exp_fetch(1, 23, "R2");
    @(negedge clk) run_set_i = 1'b1;
    @(negedge clk) run_set_i = 1'b0;
    check("R10", "err cleared on start", int'(err_o), 0);
    repeat (5) @(negedge clk);
    run_set_i = 1'b1;
    @(negedge clk) run_set_i = 1'b0;
    while (run_o) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R2", "fetch queue restart", fa_q.size(), 0);
    check("R9", "irq after wait prog", int'(irq_o), 1);
    check("R7", "mod held", int'(mod_sel_o), 'h5A);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule